// File: doc/BRIEF.md
# Programmable NAND Bus Cycle Timer

This block runs one asynchronous NAND-style bus cycle at a time. The four cycle kinds are command latch, address latch, data read and data write. The cycle is measured in whole clock ticks. Every control strobe opens and closes at its own programmable tick offset from tick 0. The strobes are chip enable, command latch, address latch, read enable and write enable. Read cycles and write-type cycles use separate values for the chip-enable close time and for the cycle length. A nanosecond figure from a flash datasheet is rounded up to whole ticks before it is programmed. For example, with an 8 ns tick a 5 ns minimum becomes 1 tick.

A request is offered on a valid/ready pair together with its kind, its write word and its timing fields. The request is taken only while the block is idle, and `req_ready` stays low for the whole transaction. The requester holds `req_valid` and the payload stable until the handshake completes, so holding valid while the block is busy is the only form of back-pressure. All timing fields are copied at the handshake, so changing them during a cycle affects only later cycles.

The read word is sampled at a programmed access tick and is presented for one clock with a `rd_valid` pulse. That output has no ready input, so the consumer must take it in that clock. Chip enable always goes high between accesses. Two kinds of idle ticks can be added around a cycle:
- turnaround ticks before a cycle whose bus direction differs from the previous cycle;
- an optional fixed gap after every cycle.

Top module: `nand_cycle_timer`

## Requirements
- R1: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the block is idle. `busy` is high from the first tick after acceptance until the block is idle again. Kind, write word and all timing fields are captured at acceptance.
- R2: With cycle tick index t (t = 0 on the first tick after acceptance, or after turnaround), `nand_ce_n` is low exactly while `ce_on <= t < off`. For read cycles `off` is `ce_off_rd`; for the other kinds it is `ce_off_wr`. `nand_ce_n` is high in turnaround ticks, in gap ticks and when idle.
- R3: In read cycles (kind code 2), `nand_re_n` is low while `re_on <= t < re_off` and `nand_we_n` stays high. In command (0), address (1) and write (3) cycles, `nand_we_n` is low while `we_on <= t < we_off` and `nand_re_n` stays high.
- R4: `nand_cle` is high only in command cycles, and `nand_ale` only in address cycles, in both cases while `le_on <= t < le_off`.
- R5: A strobe whose off time is less than or equal to its on time never asserts. An off time beyond the cycle length ends the strobe at the last tick, so no strobe is active outside a cycle.
- R6: A read cycle lasts `len_rd` ticks and the other kinds last `len_wr` ticks; a length of 0 is treated as 1. `done` is high on the last tick of the cycle only.
- R7: `dq_oe` is high on every tick of command, address and write cycles, and `dq_out` then carries the accepted write word. `dq_oe` is low in read cycles, turnaround ticks, gap ticks and when idle.
- R8: In a read cycle, `dq_in` is registered at the end of tick `acc_tick`. If `acc_tick` is at or beyond the cycle length, it is registered at the end of the last tick instead. The captured word appears on `rd_data` with `rd_valid` high for exactly one clock, the clock after that tick.
- R9: When `gap_en` is high, `gap_len` ticks with `busy` high and `nand_ce_n` high follow each cycle before a new request can be accepted.
- R10: When the direction of a cycle (read versus not read) differs from that of the previous cycle, `turn_len` ticks with `busy` high and all strobes inactive come before tick 0. The direction after reset counts as write.
- R11: After reset the block is idle: `req_ready` is high, `nand_ce_n`, `nand_re_n` and `nand_we_n` are high, `nand_cle`, `nand_ale`, `dq_oe`, `done` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | Kind: 0 command, 1 address, 2 read, 3 write |
| req_wdata | input | DW | Word driven in non-read cycles |
| ce_on | input | ON_W | Chip-enable open tick |
| ce_off_rd | input | OFF_W | Chip-enable close tick, read cycles |
| ce_off_wr | input | OFF_W | Chip-enable close tick, other cycles |
| le_on | input | ON_W | Latch strobe open tick |
| le_off | input | OFF_W | Latch strobe close tick |
| re_on | input | ON_W | Read-enable open tick |
| re_off | input | OFF_W | Read-enable close tick |
| we_on | input | ON_W | Write-enable open tick |
| we_off | input | OFF_W | Write-enable close tick |
| len_rd | input | OFF_W | Read cycle length in ticks |
| len_wr | input | OFF_W | Non-read cycle length in ticks |
| acc_tick | input | OFF_W | Read sample tick |
| gap_en | input | 1 | Enable post-cycle gap |
| gap_len | input | GW | Post-cycle gap length |
| turn_len | input | GW | Direction-change turnaround length |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch, active high |
| nand_ale | output | 1 | Address latch, active high |
| nand_re_n | output | 1 | Read enable, active low |
| nand_we_n | output | 1 | Write enable, active low |
| dq_out | output | DW | Data bus out |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | DW | Data bus in |
| rd_data | output | DW | Captured read word |
| rd_valid | output | 1 | One-clock pulse with `rd_data` |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Last tick of a cycle |

## Verification
Two corner cases are hard to reach from the ports. The first is a request that arrives while a gap or turnaround is still running, with different timing fields on the pins. The second is a read sample tick clamped to the last tick, so that the `rd_valid` pulse falls outside the cycle, in the following idle or gap tick. The stimulus reaches both by presenting each new request, with new fields, immediately after the previous one is accepted. It also deliberately programs lengths of 0, off times at or below on times, and off and access ticks beyond the cycle length. A behavioural model expands every accepted request into a queue of per-tick expectations. It tracks the read pulse with a separate countdown, so the pulse is checked correctly when it lands past the end of the cycle.

// File: rtl/nct_pkg.sv
package nct_pkg;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } nct_op_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_TURN = 2'd1,
    PH_CYC  = 2'd2,
    PH_GAP  = 2'd3
  } nct_phase_e;

endpackage

// File: rtl/nct_sequencer.sv
module nct_sequencer
  import nct_pkg::*;
#(
  parameter int TW = 5,
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_is_rd,
  input  logic [TW-1:0] len_rd,
  input  logic [TW-1:0] len_wr,
  input  logic [GW-1:0] turn_len,
  input  logic          gap_en,
  input  logic [GW-1:0] gap_len,
  output logic          req_ready,
  output logic          accept,
  output logic          busy,
  output logic          cyc_active,
  output logic [TW-1:0] tick,
  output logic          last_tick
);

  localparam logic [TW-1:0] ONE_T = TW'(1);
  localparam logic [GW-1:0] ONE_G = GW'(1);

  nct_phase_e    phase_q;
  logic [TW-1:0] tick_q;
  logic [TW-1:0] len_q;
  logic [GW-1:0] cnt_q;
  logic [GW-1:0] gap_q;
  logic          prev_rd_q;
  logic [TW-1:0] len_pick;

  assign len_pick   = req_is_rd ? len_rd : len_wr;
  assign req_ready  = (phase_q == PH_IDLE);
  assign accept     = req_valid && req_ready;
  assign busy       = (phase_q != PH_IDLE);
  assign cyc_active = (phase_q == PH_CYC);
  assign tick       = tick_q;
  assign last_tick  = cyc_active && (tick_q == len_q - ONE_T);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      tick_q    <= '0;
      len_q     <= ONE_T;
      cnt_q     <= '0;
      gap_q     <= '0;
      prev_rd_q <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            len_q     <= (len_pick == '0) ? ONE_T : len_pick;
            gap_q     <= gap_en ? gap_len : '0;
            prev_rd_q <= req_is_rd;
            tick_q    <= '0;
            if ((req_is_rd != prev_rd_q) && (turn_len != '0)) begin
              phase_q <= PH_TURN;
              cnt_q   <= turn_len;
            end else begin
              phase_q <= PH_CYC;
            end
          end
        end
        PH_TURN: begin
          if (cnt_q == ONE_G) phase_q <= PH_CYC;
          else                cnt_q   <= cnt_q - ONE_G;
        end
        PH_CYC: begin
          if (last_tick) begin
            if (gap_q != '0) begin
              phase_q <= PH_GAP;
              cnt_q   <= gap_q;
            end else begin
              phase_q <= PH_IDLE;
            end
          end else begin
            tick_q <= tick_q + ONE_T;
          end
        end
        default: begin
          if (cnt_q == ONE_G) phase_q <= PH_IDLE;
          else                cnt_q   <= cnt_q - ONE_G;
        end
      endcase
    end
  end

  // R1
  accept_to_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R6
  done_ends_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |=> !cyc_active);

endmodule

// File: rtl/nct_window.sv
module nct_window #(
  parameter int TW = 5
) (
  input  logic          en,
  input  logic [TW-1:0] tick,
  input  logic [TW-1:0] on_t,
  input  logic [TW-1:0] off_t,
  output logic          active
);

  assign active = en && (tick >= on_t) && (tick < off_t);

endmodule

// File: rtl/nct_capture.sv
module nct_capture #(
  parameter int DW = 8,
  parameter int TW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_cycle,
  input  logic          last_tick,
  input  logic [TW-1:0] tick,
  input  logic [TW-1:0] acc_tick,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  logic sample;

  assign sample = rd_cycle &&
                  ((tick == acc_tick) || (last_tick && (acc_tick > tick)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= sample;
      if (sample) rd_data <= dq_in;
    end
  end

  // R8
  rd_pulse_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_cycle));

  // R8
  rd_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid || $past(rd_cycle));

endmodule

// File: rtl/nand_cycle_timer.sv
module nand_cycle_timer
  import nct_pkg::*;
#(
  parameter int DW    = 8,
  parameter int ON_W  = 4,
  parameter int OFF_W = 5,
  parameter int GW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [DW-1:0]    req_wdata,
  input  logic [ON_W-1:0]  ce_on,
  input  logic [OFF_W-1:0] ce_off_rd,
  input  logic [OFF_W-1:0] ce_off_wr,
  input  logic [ON_W-1:0]  le_on,
  input  logic [OFF_W-1:0] le_off,
  input  logic [ON_W-1:0]  re_on,
  input  logic [OFF_W-1:0] re_off,
  input  logic [ON_W-1:0]  we_on,
  input  logic [OFF_W-1:0] we_off,
  input  logic [OFF_W-1:0] len_rd,
  input  logic [OFF_W-1:0] len_wr,
  input  logic [OFF_W-1:0] acc_tick,
  input  logic             gap_en,
  input  logic [GW-1:0]    gap_len,
  input  logic [GW-1:0]    turn_len,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_re_n,
  output logic             nand_we_n,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done
);

  localparam int TW   = OFF_W;
  localparam int NWIN = 4;
  localparam int W_CE = 0;
  localparam int W_LE = 1;
  localparam int W_RE = 2;
  localparam int W_WE = 3;

  logic             accept;
  logic             cyc_active;
  logic             last_tick;
  logic [TW-1:0]    tick;

  nct_op_e          op_q;
  logic [DW-1:0]    wdata_q;
  logic [ON_W-1:0]  ce_on_q, le_on_q, re_on_q, we_on_q;
  logic [OFF_W-1:0] ce_off_rd_q, ce_off_wr_q, le_off_q, re_off_q, we_off_q;
  logic [OFF_W-1:0] acc_q;

  logic             is_rd;
  logic             is_latch;

  nct_sequencer #(.TW(TW), .GW(GW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_is_rd  (req_op == OP_READ),
    .len_rd     (len_rd),
    .len_wr     (len_wr),
    .turn_len   (turn_len),
    .gap_en     (gap_en),
    .gap_len    (gap_len),
    .req_ready  (req_ready),
    .accept     (accept),
    .busy       (busy),
    .cyc_active (cyc_active),
    .tick       (tick),
    .last_tick  (last_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q        <= OP_WRITE;
      wdata_q     <= '0;
      ce_on_q     <= '0;
      le_on_q     <= '0;
      re_on_q     <= '0;
      we_on_q     <= '0;
      ce_off_rd_q <= '0;
      ce_off_wr_q <= '0;
      le_off_q    <= '0;
      re_off_q    <= '0;
      we_off_q    <= '0;
      acc_q       <= '0;
    end else if (accept) begin
      op_q        <= nct_op_e'(req_op);
      wdata_q     <= req_wdata;
      ce_on_q     <= ce_on;
      le_on_q     <= le_on;
      re_on_q     <= re_on;
      we_on_q     <= we_on;
      ce_off_rd_q <= ce_off_rd;
      ce_off_wr_q <= ce_off_wr;
      le_off_q    <= le_off;
      re_off_q    <= re_off;
      we_off_q    <= we_off;
      acc_q       <= acc_tick;
    end
  end

  assign is_rd    = (op_q == OP_READ);
  assign is_latch = (op_q == OP_CMD) || (op_q == OP_ADDR);

  logic [NWIN-1:0] win_en;
  logic [TW-1:0]   win_on  [NWIN];
  logic [TW-1:0]   win_off [NWIN];
  logic [NWIN-1:0] win_act;

  always_comb begin
    win_en[W_CE]  = cyc_active;
    win_on[W_CE]  = TW'(ce_on_q);
    win_off[W_CE] = is_rd ? ce_off_rd_q : ce_off_wr_q;
    win_en[W_LE]  = cyc_active && is_latch;
    win_on[W_LE]  = TW'(le_on_q);
    win_off[W_LE] = le_off_q;
    win_en[W_RE]  = cyc_active && is_rd;
    win_on[W_RE]  = TW'(re_on_q);
    win_off[W_RE] = re_off_q;
    win_en[W_WE]  = cyc_active && !is_rd;
    win_on[W_WE]  = TW'(we_on_q);
    win_off[W_WE] = we_off_q;
  end

  for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
    nct_window #(.TW(TW)) u_win (
      .en     (win_en[gi]),
      .tick   (tick),
      .on_t   (win_on[gi]),
      .off_t  (win_off[gi]),
      .active (win_act[gi])
    );
  end

  assign nand_ce_n = !win_act[W_CE];
  assign nand_cle  = win_act[W_LE] && (op_q == OP_CMD);
  assign nand_ale  = win_act[W_LE] && (op_q == OP_ADDR);
  assign nand_re_n = !win_act[W_RE];
  assign nand_we_n = !win_act[W_WE];
  assign dq_oe     = cyc_active && !is_rd;
  assign dq_out    = wdata_q;
  assign done      = last_tick;

  nct_capture #(.DW(DW), .TW(TW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_cycle  (cyc_active && is_rd),
    .last_tick (last_tick),
    .tick      (tick),
    .acc_tick  (acc_q),
    .dq_in     (dq_in),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  // R3
  no_re_we_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_re_n && !nand_we_n));

  // R7
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !dq_oe);

  // R4
  one_latch_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R5
  quiet_outside_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_active |-> (nand_ce_n && nand_re_n && nand_we_n && !nand_cle && !nand_ale));

  // R2
  ce_high_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> nand_ce_n);

endmodule

// File: tb/nand_cycle_timer_bench.sv
module nand_cycle_timer_bench;

  localparam int DW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = 2'd3;
  logic [7:0] req_wdata = '0;
  logic [3:0] ce_on = '0, le_on = '0, re_on = '0, we_on = '0;
  logic [4:0] ce_off_rd = '0, ce_off_wr = '0, le_off = '0, re_off = '0, we_off = '0;
  logic [4:0] len_rd = '0, len_wr = '0, acc_tick = '0;
  logic       gap_en = 1'b0;
  logic [3:0] gap_len = '0, turn_len = '0;
  logic       nand_ce_n, nand_cle, nand_ale, nand_re_n, nand_we_n;
  logic [7:0] dq_out;
  logic       dq_oe;
  logic [7:0] dq_in = '0;
  logic [7:0] rd_data;
  logic       rd_valid, busy, done;

  always #10 clk = ~clk;

  nand_cycle_timer u_nand_cycle_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_wdata(req_wdata),
    .ce_on(ce_on), .ce_off_rd(ce_off_rd), .ce_off_wr(ce_off_wr),
    .le_on(le_on), .le_off(le_off), .re_on(re_on), .re_off(re_off),
    .we_on(we_on), .we_off(we_off), .len_rd(len_rd), .len_wr(len_wr),
    .acc_tick(acc_tick), .gap_en(gap_en), .gap_len(gap_len), .turn_len(turn_len),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_re_n(nand_re_n), .nand_we_n(nand_we_n), .dq_out(dq_out), .dq_oe(dq_oe),
    .dq_in(dq_in), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .done(done)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string cur_tag = "R11";

  // expectation vector: {busy, done, oe, we_n, re_n, ale, cle, ce_n}
  localparam logic [7:0] V_IDLE = 8'b0001_1001;
  localparam logic [7:0] V_WAIT = 8'b1001_1001;
  logic [7:0] exp_q[$];
  logic [7:0] wd_q[$];
  int  rdv_cnt = -1;
  logic [7:0] rd_exp = '0;
  bit  idle_now = 1'b1;
  bit  prev_rd_m = 1'b0;
  int  seed = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) t=%0t actual=%0h expected=%0h", req, cur_tag, $time, act, expv);
    end
  endtask

  task automatic tick();
    logic [7:0] ev;
    logic [7:0] ew;
    bit rv_exp;
    @(negedge clk);
    if (rdv_cnt > 0) rdv_cnt--;
    if (exp_q.size() == 0) begin
      idle_now = 1'b1; ev = V_IDLE; ew = '0;
    end else begin
      idle_now = 1'b0; ev = exp_q.pop_front(); ew = wd_q.pop_front();
    end
    rv_exp = (rdv_cnt == 0);
    chk(nand_ce_n == ev[0], "R2 ce_n", int'(nand_ce_n), int'(ev[0]));
    chk({nand_ale, nand_cle} == ev[2:1], "R4 ale/cle", int'({nand_ale, nand_cle}), int'(ev[2:1]));
    chk({nand_we_n, nand_re_n} == ev[4:3], "R3 we_n/re_n", int'({nand_we_n, nand_re_n}), int'(ev[4:3]));
    chk(dq_oe == ev[5], "R7 dq_oe", int'(dq_oe), int'(ev[5]));
    if (ev[5]) chk(dq_out == ew, "R7 dq_out", int'(dq_out), int'(ew));
    chk(done == ev[6], "R6 done", int'(done), int'(ev[6]));
    chk(busy == ev[7] && req_ready == !ev[7], "R1 busy/ready",
        int'({busy, req_ready}), int'({ev[7], !ev[7]}));
    chk(rd_valid == rv_exp, "R8 rd_valid", int'(rd_valid), int'(rv_exp));
    if (rv_exp) chk(rd_data == rd_exp, "R8 rd_data", int'(rd_data), int'(rd_exp));
    if (rdv_cnt == 0) rdv_cnt = -1;
    seed++;
    dq_in = 8'(seed * 37 + 5);
    if (rdv_cnt == 1) rd_exp = dq_in;
  endtask

  function automatic bit inwin(int t, int on, int off);
    return (t >= on) && (t < off);
  endfunction

  task automatic push_model();
    bit rd;
    int len, pre, gap, acc, op;
    logic [7:0] v;
    op  = int'(req_op);
    rd  = (op == 2);
    len = rd ? int'(len_rd) : int'(len_wr);
    if (len == 0) len = 1;
    pre = (rd != prev_rd_m) ? int'(turn_len) : 0;
    prev_rd_m = rd;
    gap = gap_en ? int'(gap_len) : 0;
    for (int i = 0; i < pre; i++) begin exp_q.push_back(V_WAIT); wd_q.push_back('0); end
    for (int t = 0; t < len; t++) begin
      v = V_IDLE;
      v[7] = 1'b1;
      v[0] = !inwin(t, int'(ce_on), rd ? int'(ce_off_rd) : int'(ce_off_wr));
      v[1] = (op == 0) && inwin(t, int'(le_on), int'(le_off));
      v[2] = (op == 1) && inwin(t, int'(le_on), int'(le_off));
      v[3] = !(rd && inwin(t, int'(re_on), int'(re_off)));
      v[4] = !(!rd && inwin(t, int'(we_on), int'(we_off)));
      v[5] = !rd;
      v[6] = (t == len - 1);
      exp_q.push_back(v);
      wd_q.push_back(req_wdata);
    end
    for (int i = 0; i < gap; i++) begin exp_q.push_back(V_WAIT); wd_q.push_back('0); end
    if (rd) begin
      acc = int'(acc_tick);
      if (acc >= len) acc = len - 1;
      rdv_cnt = pre + acc + 2;
    end
  endtask

  task automatic send(input string tag, input int op, input int wd);
    cur_tag   = tag;
    req_op    = 2'(op);
    req_wdata = 8'(wd);
    req_valid = 1'b1;
    forever begin
      if (idle_now) begin
        push_model();
        tick();
        break;
      end
      tick();
    end
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0 || rdv_cnt >= 0) tick();
    tick();
  endtask

  task automatic set_t(int cn, int cr, int cw, int ln, int lf, int rn, int rf,
                       int wn, int wf, int lr, int lw, int ac, int ge, int gl, int tl);
    ce_on = 4'(cn); ce_off_rd = 5'(cr); ce_off_wr = 5'(cw);
    le_on = 4'(ln); le_off = 5'(lf); re_on = 4'(rn); re_off = 5'(rf);
    we_on = 4'(wn); we_off = 5'(wf); len_rd = 5'(lr); len_wr = 5'(lw);
    acc_tick = 5'(ac); gap_en = ge[0]; gap_len = 4'(gl); turn_len = 4'(tl);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R11";
    tick();
    tick();
    // R3 plain write, no turnaround since reset direction is write (R10)
    set_t(0, 6, 6, 0, 5, 1, 5, 1, 4, 7, 7, 4, 0, 0, 2);
    send("R3", 3, 8'hA5);
    drain();
    // R4 command then address latch
    set_t(0, 6, 6, 1, 4, 1, 5, 1, 4, 7, 6, 4, 0, 0, 2);
    send("R4", 0, 8'h70);
    send("R4", 1, 8'h3C);
    drain();
    // R8 read with direction change turnaround (R10)
    set_t(0, 6, 6, 0, 5, 1, 5, 1, 4, 7, 7, 4, 0, 0, 2);
    send("R8", 2, 0);
    drain();
    // R5 clamps: re off <= on, ce off beyond length, access beyond length
    set_t(1, 31, 31, 0, 5, 3, 2, 1, 4, 5, 7, 20, 0, 0, 2);
    send("R5", 2, 0);
    drain();
    // R6 zero length read, sample at tick 0
    set_t(0, 1, 1, 0, 1, 0, 1, 0, 1, 0, 0, 0, 0, 0, 2);
    send("R6", 2, 0);
    // R6 zero length write right after, with turnaround
    send("R6", 3, 8'h5A);
    drain();
    // R9 gap on back-to-back writes held under back-pressure (R1)
    set_t(0, 4, 5, 0, 3, 1, 3, 1, 3, 4, 5, 2, 1, 3, 1);
    send("R9", 3, 8'h11);
    set_t(1, 4, 4, 0, 3, 1, 3, 2, 4, 4, 4, 2, 1, 2, 1);
    send("R1", 3, 8'h22);
    // R10 read after write with turnaround and gap, last-tick capture
    set_t(0, 9, 9, 0, 3, 2, 6, 1, 3, 6, 4, 5, 1, 2, 3);
    send("R10", 2, 0);
    set_t(0, 31, 31, 0, 31, 1, 3, 2, 31, 6, 9, 5, 0, 0, 3);
    send("R10", 0, 8'hEE);
    drain();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog (%s) actual=hung expected=finished", cur_tag);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule